// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps activity on an external input pin. The pin is asynchronous to the system clock. It passes through a two-stage synchronizer, and an edge is found by comparing the synchronized level with its value one cycle earlier. A configured mode decides which edges count. When an edge counts, the block stores the current value of one of two free-running 16-bit timer inputs in a small first-in first-out buffer. The modes are both edges, falling only, rising only, every 4th rising edge and every 16th rising edge.

A host writes the configuration through a single write strobe. The configuration holds the mode, the timer select and the interrupt threshold. The host drains stored timestamps with a read strobe. Two status outputs report that data is waiting and that a capture was lost because the buffer was full. A one-cycle interrupt pulse fires after a programmed number of stored captures, from 1 to 4. A DMA-style consumer that wants one request per capture sets the threshold to one.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, `buf_ne`, `ovf` and `irq` are 0 and `rd_data` is 0.
- R2: A pin change driven between clock edges is stored on the third rising clock edge after it. `buf_ne` is still 0 after two edges and is 1 after the third.
- R3: The mode codes work as follows. 3'b001 stores on both edges, 3'b010 on falling edges only and 3'b011 on rising edges only. Edges that the mode does not select store nothing.
- R4: Mode 3'b100 stores on every 4th rising edge and mode 3'b101 on every 16th. Counting starts from the most recent configuration write.
- R5: Mode codes 3'b000, 3'b110 and 3'b111 are off. In these modes no edge is stored and the entries already in the buffer are kept.
- R6: `ctl_tsel` = 0 stores `tmr_a` as sampled on the storing clock edge. `ctl_tsel` = 1 stores `tmr_b`.
- R7: The buffer holds 4 entries. A read strobe on a non-empty buffer pops the oldest entry. The popped value appears on `rd_data` after the next clock edge.
- R8: A qualifying edge that arrives while 4 entries are held is discarded and sets `ovf`. `ovf` stays 1 until a read empties the buffer.
- R9: A read strobe on an empty buffer leaves `rd_data`, `buf_ne` and `ovf` unchanged.
- R10: `irq` pulses high for one cycle on each Nth stored capture, where N = `ctl_irqn` + 1 (2'b00 gives 1, 2'b11 gives 4). The pulse is visible in the cycle after the storing edge.
- R11: A configuration write clears the prescale count and the interrupt capture count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_in | input | 1 | Asynchronous capture pin |
| tmr_a | input | 16 | First timer value |
| tmr_b | input | 16 | Second timer value |
| ctl_wr | input | 1 | Configuration write strobe |
| ctl_mode | input | 3 | Edge/prescale mode |
| ctl_tsel | input | 1 | Timer select |
| ctl_irqn | input | 2 | Captures per interrupt minus one |
| rd_en | input | 1 | Buffer read strobe |
| rd_data | output | 16 | Last popped timestamp |
| buf_ne | output | 1 | Buffer holds data |
| ovf | output | 1 | A capture was lost |
| irq | output | 1 | Interrupt pulse |

## Verification
The single-cycle interrupt property assumes that the pin holds each level for at least two clock cycles. Under that assumption, two stored captures can never fall on consecutive edges. The bench holds every pin level for three cycles and keeps the timer inputs constant around each capture, so every expected timestamp is exact. The bench never issues a read in the same cycle as a capture, so the fill level seen by the overflow properties changes one cause at a time.

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int TW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_in,
  input  logic [TW-1:0] tmr_a,
  input  logic [TW-1:0] tmr_b,
  input  logic          ctl_wr,
  input  logic [2:0]    ctl_mode,
  input  logic          ctl_tsel,
  input  logic [1:0]    ctl_irqn,
  input  logic          rd_en,
  output logic [TW-1:0] rd_data,
  output logic          buf_ne,
  output logic          ovf,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [2:0]    sh;
  logic [2:0]    mode_q;
  logic          tsel_q;
  logic [1:0]    irqn_q;
  logic [3:0]    pre_cnt;
  logic [1:0]    irq_cnt;
  logic [TW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   fill;
  logic          rise, fall, pre_hit, ev, wr, drop, pop;

  assign rise    = sh[1] & ~sh[2];
  assign fall    = ~sh[1] & sh[2];
  assign pre_hit = pre_cnt == ((mode_q == 3'b100) ? 4'd3 : 4'd15);

  always_comb begin
    case (mode_q)
      3'b001:         ev = rise | fall;
      3'b010:         ev = fall;
      3'b011:         ev = rise;
      3'b100, 3'b101: ev = rise & pre_hit;
      default:        ev = 1'b0;
    endcase
  end

  assign wr     = ev && (fill != FULL);
  assign drop   = ev && (fill == FULL);
  assign pop    = rd_en && (fill != '0);
  assign buf_ne = fill != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], cap_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      tsel_q <= 1'b0;
      irqn_q <= '0;
    end else if (ctl_wr) begin
      mode_q <= ctl_mode;
      tsel_q <= ctl_tsel;
      irqn_q <= ctl_irqn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctl_wr)
      pre_cnt <= '0;
    else if (mode_q == 3'b100 || mode_q == 3'b101) begin
      if (rise) pre_cnt <= pre_hit ? 4'd0 : pre_cnt + 4'd1;
    end else
      pre_cnt <= '0;
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= tsel_q ? tmr_b : tmr_a;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      fill    <= '0;
      rd_data <= '0;
      ovf     <= 1'b0;
    end else begin
      if (wr) wp <= wp + 1'b1;
      if (pop) begin
        rp      <= rp + 1'b1;
        rd_data <= mem[rp];
      end
      case ({wr, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (drop)                             ovf <= 1'b1;
      else if (pop && !wr && fill == 1)     ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctl_wr) begin
      irq_cnt <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wr) begin
        if (irq_cnt == irqn_q) begin
          irq_cnt <= '0;
          irq     <= 1'b1;
        end else
          irq_cnt <= irq_cnt + 2'd1;
      end
    end
  end
endmodule

module edge_capture_unit_chk #(
  parameter int TW = 16,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          irq,
  input logic          buf_ne,
  input logic          ovf,
  input logic [TW-1:0] rd_data,
  input logic [AW:0]   fill,
  input logic [2:0]    mode_q
);
  localparam logic [AW:0] FULL = (AW+1)'(1 << AW);

  p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL);

  p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(fill) == FULL);

  p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(rd_en && fill == 1)) |=> ovf);

  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !buf_ne) |=> $stable(rd_data));

  p_off_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 3'b000 || mode_q == 3'b110 || mode_q == 3'b111) && !rd_en)
      |=> fill == $past(fill));

  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

bind edge_capture_unit edge_capture_unit_chk #(.TW(TW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .irq(irq), .buf_ne(buf_ne),
  .ovf(ovf), .rd_data(rd_data), .fill(fill), .mode_q(mode_q)
);

// File: tb/edge_capture_unit_tb.sv
module edge_capture_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cap_in = 0;
  logic [15:0] tmr_a = 0, tmr_b = 0;
  logic        ctl_wr = 0;
  logic [2:0]  ctl_mode = 0;
  logic        ctl_tsel = 0;
  logic [1:0]  ctl_irqn = 0;
  logic        rd_en = 0;
  logic [15:0] rd_data;
  logic        buf_ne, ovf, irq;
  int checks = 0, errors = 0;
  int irq_seen;
  bit done = 0;

  always #5 clk = ~clk;

  edge_capture_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .tmr_a(tmr_a), .tmr_b(tmr_b),
    .ctl_wr(ctl_wr), .ctl_mode(ctl_mode), .ctl_tsel(ctl_tsel),
    .ctl_irqn(ctl_irqn), .rd_en(rd_en), .rd_data(rd_data),
    .buf_ne(buf_ne), .ovf(ovf), .irq(irq)
  );

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) irq_seen++;
    end
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [2:0] m, logic ts, logic [1:0] n);
    ctl_mode = m; ctl_tsel = ts; ctl_irqn = n; ctl_wr = 1;
    step(1);
    ctl_wr = 0;
  endtask

  task automatic pin(logic v);
    cap_in = v;
    step(3);
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      pin(1); pin(0);
    end
  endtask

  task automatic rd(output logic [15:0] v);
    rd_en = 1;
    step(1);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic drain();
    logic [15:0] v;
    while (buf_ne) rd(v);
  endtask

  task automatic t_reset();
    check(!buf_ne && !ovf && !irq && rd_data == 0, "R1", {buf_ne, ovf, irq}, 0);
  endtask

  task automatic t_latency();
    logic [15:0] v;
    cfg(3'b011, 0, 0);
    tmr_a = 16'h1234;
    cap_in = 1;
    step(2);
    check(!buf_ne, "R2 early", buf_ne, 0);
    step(1);
    check(buf_ne, "R2 third edge", buf_ne, 1);
    rd(v);
    check(v == 16'h1234, "R2 value", v, 16'h1234);
    pin(0); step(1);
    check(!buf_ne, "R3 rise mode ignores fall", buf_ne, 0);
  endtask

  task automatic t_modes();
    logic [15:0] v;
    cfg(3'b001, 0, 0);
    tmr_a = 16'h0a01; pin(1);
    tmr_a = 16'h0a02; pin(0);
    rd(v); check(v == 16'h0a01, "R3 both rise / R7 order", v, 16'h0a01);
    rd(v); check(v == 16'h0a02, "R3 both fall / R7 order", v, 16'h0a02);
    cfg(3'b010, 0, 0);
    tmr_a = 16'h0b01; pin(1);
    check(!buf_ne, "R3 fall mode ignores rise", buf_ne, 0);
    tmr_a = 16'h0b02; pin(0);
    rd(v); check(v == 16'h0b02, "R3 fall mode", v, 16'h0b02);
  endtask

  task automatic t_tsel();
    logic [15:0] v;
    cfg(3'b011, 1, 0);
    tmr_a = 16'haaaa; tmr_b = 16'hbbbb;
    pulse(1);
    rd(v); check(v == 16'hbbbb, "R6 timer b", v, 16'hbbbb);
    cfg(3'b011, 0, 0);
    pulse(1);
    rd(v); check(v == 16'haaaa, "R6 timer a", v, 16'haaaa);
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    cfg(3'b100, 0, 0);
    tmr_a = 16'h0004;
    pulse(3);
    check(!buf_ne, "R4 div4 before 4th", buf_ne, 0);
    pulse(1);
    check(buf_ne, "R4 div4 on 4th", buf_ne, 1);
    rd(v); check(v == 16'h0004, "R4 div4 value", v, 4);
    cfg(3'b101, 0, 0);
    tmr_a = 16'h0016;
    pulse(15);
    check(!buf_ne, "R4 div16 before 16th", buf_ne, 0);
    pulse(1);
    check(buf_ne, "R4 div16 on 16th", buf_ne, 1);
    drain();
  endtask

  task automatic t_ctl_clear();
    cfg(3'b100, 0, 0);
    pulse(2);
    cfg(3'b100, 0, 0);
    pulse(3);
    check(!buf_ne, "R11 prescale cleared", buf_ne, 0);
    pulse(1);
    check(buf_ne, "R11 4th after rewrite", buf_ne, 1);
    drain();
  endtask

  task automatic t_off();
    logic [15:0] v;
    cfg(3'b011, 0, 0);
    tmr_a = 16'h0c01; pulse(1);
    tmr_a = 16'h0c02; pulse(1);
    cfg(3'b000, 0, 0);
    tmr_a = 16'h0c03; pulse(2);
    cfg(3'b110, 0, 0); pulse(1);
    cfg(3'b111, 0, 0); pulse(1);
    rd(v); check(v == 16'h0c01, "R5 kept entry 1", v, 16'h0c01);
    rd(v); check(v == 16'h0c02, "R5 kept entry 2", v, 16'h0c02);
    check(!buf_ne, "R5 nothing added", buf_ne, 0);
  endtask

  task automatic t_overflow();
    logic [15:0] v;
    cfg(3'b011, 0, 0);
    for (int i = 1; i <= 5; i++) begin
      tmr_a = 16'(i); pulse(1);
    end
    check(ovf, "R8 overflow set", ovf, 1);
    for (int i = 1; i <= 4; i++) begin
      rd(v);
      check(v == 16'(i), "R8 oldest four kept", v, i);
      if (i < 4) check(ovf, "R8 overflow held", ovf, 1);
    end
    check(!ovf && !buf_ne, "R8 cleared when empty", ovf, 0);
  endtask

  task automatic t_empty_read();
    logic [15:0] v;
    rd(v);
    check(v == 16'h0004 && !buf_ne && !ovf, "R9 empty read", v, 4);
  endtask

  task automatic t_irq();
    cfg(3'b011, 0, 2'b10);
    irq_seen = 0;
    pulse(2);
    check(irq_seen == 0, "R10 no irq before 3", irq_seen, 0);
    pulse(1);
    check(irq_seen == 1, "R10 one pulse on 3rd", irq_seen, 1);
    drain();
    cfg(3'b011, 0, 2'b00);
    irq_seen = 0;
    pulse(2);
    check(irq_seen == 2, "R10 every capture", irq_seen, 2);
    drain();
    cfg(3'b011, 0, 2'b01);
    irq_seen = 0;
    pulse(1);
    cfg(3'b011, 0, 2'b01);
    pulse(1);
    check(irq_seen == 0, "R11 irq count cleared", irq_seen, 0);
    drain();
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_latency();
    t_modes();
    t_tsel();
    t_prescale();
    t_ctl_clear();
    t_off();
    t_overflow();
    t_empty_read();
    t_irq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule